// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Status

This block sits between the deserializer of an asynchronous serial receiver and the host-side read logic. Each received character enters an eight-deep queue together with three error flags: break detected, framing error and parity error. The host pops characters in arrival order. It also reads an eight-bit status word. That word combines the error flags with live indications: queue occupancy, overrun, and two transmitter state bits supplied from outside.

The flags can be reported in one of two ways. In per-character reporting, the status flags are those of the character at the head of the queue. In cumulative reporting, the status flags are the OR of the flags of every character accepted since the last clear, and they stay set as characters leave. A four-bit command input carries two operations. One clears the error state. The other resets the receiver side, which empties the queue and clears all error state. Any other command value does nothing.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset, `status` reads {3'b000, 1'b0, tx_empty, tx_ready, 1'b0, 1'b0} and `rd_data` reads 0.
- R2: Characters leave in the order they were accepted. A pop of a non-empty queue places the head character on `rd_data` from the next clock edge onward.
- R3: `status[0]` (receiver ready) is 1 exactly when at least one character is stored. `status[1]` (queue full) is 1 exactly when all DEPTH entries are occupied.
- R4: A push while the queue is full and no pop occurs in the same cycle is discarded, the stored characters are kept, and `status[4]` (overrun) is set. A push and a pop in the same cycle on a full queue are both accepted, with no overrun.
- R5: Overrun stays set until an error-clear command (`cmd_op` = 4'h4) or a receiver-reset command (`cmd_op` = 4'h2) is issued with `cmd_we`.
- R6: With `blk_mode` = 0, `status[7:5]` = {break, framing, parity} of the head character. When the queue is empty, they show the flags of the most recently popped character until cleared.
- R7: With `blk_mode` = 1, `status[7:5]` is the OR of the flags of all characters accepted since the last clear. Pops and an empty queue do not change them.
- R8: The error-clear command (4'h4) zeroes overrun, accumulated flags and held flags, and leaves stored characters untouched. A push, drop or pop in the same cycle takes effect after the clear, so its flags or its overrun remain visible.
- R9: The receiver-reset command (4'h2) empties the queue and clears all error state in one cycle. It overrides a push or pop in the same cycle and leaves `rd_data` unchanged.
- R10: A pop while the queue is empty changes neither `rd_data` nor `status`.
- R11: `status[3]` follows `tx_empty` and `status[2]` follows `tx_ready` combinationally. Command values other than 4'h2 and 4'h4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_push | input | 1 | Deserializer presents a character this cycle |
| rx_data | input | DATA_W | Received character |
| rx_brk | input | 1 | Break detected with this character |
| rx_frm | input | 1 | Framing error on this character |
| rx_par | input | 1 | Parity error on this character |
| rd_pop | input | 1 | Host removes the head character |
| rd_data | output | DATA_W | Last character popped |
| cmd_we | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code: 4'h2 receiver reset, 4'h4 error clear |
| blk_mode | input | 1 | 0 per-character flags, 1 cumulative flags |
| tx_empty | input | 1 | Transmitter empty, mirrored into status |
| tx_ready | input | 1 | Transmitter ready, mirrored into status |
| status | output | 8 | {brk, frm, par, overrun, tx_empty, tx_ready, full, ready} |

## Verification
Several functions can coincide in one cycle. A push and a pop can arrive together on a full queue. An error-clear can arrive together with a new flagged push or a dropped push. A receiver reset can arrive together with a push. The bench provokes each of these pairs deliberately by raising both inputs on the same edge. It judges the result against a queue model that applies the clear first and the new event second. The model also checks that data leaving the queue keeps its order and that the dropped character never appears.

// File: rtl/rxq_pkg.sv
// Shared types for the receive character queue.
// Assumes: three error flags per character, four-bit command codes.
package rxq_pkg;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

    typedef enum logic [3:0] {
        CMD_RX_RESET  = 4'h2,
        CMD_ERR_CLEAR = 4'h4
    } rxq_cmd_e;
endpackage

// File: rtl/rxq_store.sv
// Circular character store with a registered read port.
// Does: keeps DEPTH entries of W bits and accepts a write on a full store
// only when a read leaves in the same cycle. Flush empties it in one cycle.
// Assumes: flush outranks reads and writes; rd_q holds its value on flush.
module rxq_store #(
    parameter int DEPTH = 8,
    parameter int W     = 11,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_req,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_req,
    output logic [W-1:0]  head,
    output logic [W-1:0]  rd_q,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          wr_ok,
    output logic          rd_ok
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Occupancy flags and acceptance decisions.
    always_comb begin
        empty = (count_q == '0);
        full  = (count_q == CW'(DEPTH));
        rd_ok = rd_req && !empty && !flush;
        wr_ok = wr_req && !flush && (!full || rd_ok);
        head  = mem[rd_ptr];
        count = count_q;
    end

    // Entry storage: written only on an accepted push.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
            if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
            count_q <= count_q + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Read register: loads the head on an accepted pop, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_ok) rd_q <= mem[rd_ptr];
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !rd_req && !flush) |=> $stable(count_q));
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty && !flush) |=> $stable(rd_q));
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && $stable(rd_q));
endmodule

// File: rtl/rxq_errtrk.sv
// Error state tracker: cumulative flags, last-popped flags and overrun.
// Does: applies a clear first and the same cycle's events after it.
// Assumes: clr_all (receiver reset) outranks everything.
module rxq_errtrk
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_all,
    input  logic       clr_err,
    input  logic       push_ok,
    input  rxq_flags_t push_flags,
    input  logic       drop,
    input  logic       pop_ok,
    input  rxq_flags_t pop_flags,
    output rxq_flags_t acc_q,
    output rxq_flags_t hold_q,
    output logic       ovr_q
);
    // Sticky error state update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            acc_q  <= '0;
            hold_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            acc_q  <= (clr_err ? rxq_flags_t'('0) : acc_q)
                      | (push_ok ? push_flags : rxq_flags_t'('0));
            hold_q <= pop_ok ? pop_flags : (clr_err ? rxq_flags_t'('0) : hold_q);
            ovr_q  <= drop | (ovr_q & ~clr_err);
        end
    end

    p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_err && !clr_all) |=> ovr_q);
    p_acc_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_err && !clr_all) |=> ((acc_q & $past(acc_q)) == $past(acc_q)));
    p_rx_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (acc_q == '0) && (hold_q == '0) && !ovr_q);
endmodule

// File: rtl/rx_err_fifo.sv
// Receive character queue with per-character error flags and a status word.
// Does: stores characters with their flags, decodes the two commands and
// builds the status word. Assumes: status[7:5] choose head flags or
// cumulative flags by blk_mode; other command values are ignored.
module rx_err_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int EW    = DATA_W + FLAG_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_brk,
    input  logic              rx_frm,
    input  logic              rx_par,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmd_we,
    input  logic [3:0]        cmd_op,
    input  logic              blk_mode,
    input  logic              tx_empty,
    input  logic              tx_ready,
    output logic [7:0]        status
);
    logic          rx_clr, err_clr;
    logic [EW-1:0] wr_entry, head_entry, rd_entry;
    logic [CW-1:0] count;
    logic          full, empty, wr_ok, rd_ok, drop;
    rxq_flags_t    in_flags, head_flags, acc_q, hold_q, shown;
    logic          ovr_q;

    // Command decode and entry packing.
    always_comb begin
        rx_clr   = cmd_we && (cmd_op == CMD_RX_RESET);
        err_clr  = cmd_we && (cmd_op == CMD_ERR_CLEAR);
        in_flags = '{brk: rx_brk, frm: rx_frm, par: rx_par};
        wr_entry = {in_flags, rx_data};
        drop     = rx_push && !wr_ok && !rx_clr;
    end

    rxq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_clr),
        .wr_req  (rx_push),
        .wr_data (wr_entry),
        .rd_req  (rd_pop),
        .head    (head_entry),
        .rd_q    (rd_entry),
        .count   (count),
        .full    (full),
        .empty   (empty),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok)
    );

    assign head_flags = rxq_flags_t'(head_entry[EW-1:DATA_W]);

    rxq_errtrk u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (rx_clr),
        .clr_err    (err_clr),
        .push_ok    (wr_ok),
        .push_flags (in_flags),
        .drop       (drop),
        .pop_ok     (rd_ok),
        .pop_flags  (head_flags),
        .acc_q      (acc_q),
        .hold_q     (hold_q),
        .ovr_q      (ovr_q)
    );

    // Status word assembly.
    always_comb begin
        if (blk_mode)   shown = acc_q;
        else if (!empty) shown = head_flags;
        else            shown = hold_q;
        status  = {shown, ovr_q, tx_empty, tx_ready, full, (count != '0)};
        rd_data = rd_entry[DATA_W-1:0];
    end

    p_blk_pop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && rd_pop && !cmd_we && !rx_push)
        |=> (!blk_mode || (status[7:5] == $past(status[7:5]))));
    p_drop_sets_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && full && !rd_pop && !rx_clr) |=> status[4]);
endmodule

// File: tb/rx_err_fifo_bench.sv
`timescale 1ns/1ps
module rx_err_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n, rx_push, rx_brk, rx_frm, rx_par, rd_pop, cmd_we;
    logic       blk_mode, tx_empty, tx_ready;
    logic [7:0] rx_data, rd_data, status;
    logic [3:0] cmd_op;

    always #2 clk = ~clk;

    rx_err_fifo u_rx_err_fifo (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_data(rx_data),
        .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_par(rx_par), .rd_pop(rd_pop),
        .rd_data(rd_data), .cmd_we(cmd_we), .cmd_op(cmd_op),
        .blk_mode(blk_mode), .tx_empty(tx_empty), .tx_ready(tx_ready),
        .status(status)
    );

    typedef struct { logic [7:0] d; logic [2:0] f; } item_t;
    item_t      exp_q[$];
    logic [2:0] m_acc, m_hold;
    logic       m_ovr;
    logic [7:0] last_rd;
    logic       mon_arm = 1'b0;
    logic [7:0] mon_exp;
    int         checks = 0, errors = 0;
    bit         done = 0;

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        logic [2:0] f;
        if (blk_mode)               f = m_acc;
        else if (exp_q.size() > 0)  f = exp_q[0].f;
        else                        f = m_hold;
        return {f, m_ovr, tx_empty, tx_ready, exp_q.size() == 8, exp_q.size() > 0};
    endfunction

    // Driver: applies one cycle of stimulus, updates the model, checks status.
    task automatic step(input bit psh, input logic [7:0] d, input logic [2:0] f,
                        input bit pp, input bit cv, input logic [3:0] op, input string req);
        int  n;
        bit  rxr, er, pop_ok, push_ok, arm;
        logic [7:0] pend;
        item_t it;
        n = exp_q.size();
        rxr = cv && op == 4'h2;
        er  = cv && op == 4'h4;
        pop_ok  = pp && n > 0 && !rxr;
        push_ok = psh && !rxr && (n < 8 || pop_ok);
        arm = 0; pend = '0;
        @(negedge clk);
        rx_push = psh; rx_data = d; {rx_brk, rx_frm, rx_par} = f;
        rd_pop = pp; cmd_we = cv; cmd_op = op;
        if (rxr) begin
            exp_q.delete(); m_acc = 0; m_hold = 0; m_ovr = 0;
        end else begin
            if (er) begin m_acc = 0; m_hold = 0; m_ovr = 0; end
            if (pop_ok) begin
                it = exp_q.pop_front(); m_hold = it.f;
                arm = 1; pend = it.d; last_rd = it.d;
            end
            if (push_ok) begin
                it.d = d; it.f = f; exp_q.push_back(it); m_acc |= f;
            end else if (psh) m_ovr = 1;
        end
        @(posedge clk);
        if (arm) begin mon_exp = pend; mon_arm = 1; end
        #1;
        rx_push = 0; rd_pop = 0; cmd_we = 0; cmd_op = 0;
        chk8(req, status, exp_stat());
    endtask

    // Monitor: compares each popped character against the scoreboard (R2).
    always @(negedge clk) begin
        if (mon_arm) begin
            chk8("R2 order", rd_data, mon_exp);
            mon_arm = 0;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_push = 0; rx_data = 0; rx_brk = 0; rx_frm = 0; rx_par = 0;
        rd_pop = 0; cmd_we = 0; cmd_op = 0; blk_mode = 0; tx_empty = 1; tx_ready = 0;
        m_acc = 0; m_hold = 0; m_ovr = 0; last_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk8("R1 status", status, 8'h08);
        chk8("R1 rd_data", rd_data, 8'h00);
        tx_empty = 0; tx_ready = 1; #1;
        chk8("R11 tx mirror", status, 8'h04);

        // Per-character flags (R6)
        step(1, 8'hA5, 3'b000, 0, 0, 0, "R3 ready");
        step(1, 8'h3C, 3'b100, 0, 0, 0, "R6 head");
        step(1, 8'h7E, 3'b011, 0, 0, 0, "R6 head");
        step(0, 0, 0, 1, 0, 0, "R6 next head");
        step(0, 0, 0, 1, 0, 0, "R6 next head");
        step(0, 0, 0, 1, 0, 0, "R6 held after empty");
        step(0, 0, 0, 1, 0, 0, "R10 empty pop status");
        chk8("R10 rd_data kept", rd_data, last_rd);
        step(0, 0, 0, 0, 1, 4'h1, "R11 unknown cmd");
        step(0, 0, 0, 0, 1, 4'h4, "R8 clear held");

        // Fill, overrun, simultaneous push and pop at full (R3 R4 R5)
        for (int i = 0; i < 8; i++)
            step(1, 8'h10 + 8'(i), (i == 3) ? 3'b001 : 3'b000, 0, 0, 0, "R3 fill");
        step(1, 8'hEE, 3'b111, 0, 0, 0, "R4 overrun drop");
        step(0, 0, 0, 0, 0, 0, "R5 overrun sticky");
        step(0, 0, 0, 0, 1, 4'h4, "R5 overrun cleared");
        step(1, 8'h18, 3'b000, 1, 0, 0, "R4 push pop at full");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 0, "R2 drain");

        // Cumulative flags (R7 R8)
        blk_mode = 1;
        step(0, 0, 0, 0, 1, 4'h4, "R7 start clean");
        step(1, 8'h41, 3'b100, 0, 0, 0, "R7 accumulate");
        step(1, 8'h42, 3'b010, 0, 0, 0, "R7 accumulate");
        step(1, 8'h43, 3'b000, 0, 0, 0, "R7 accumulate");
        step(0, 0, 0, 1, 0, 0, "R7 pop keeps");
        step(0, 0, 0, 1, 0, 0, "R7 pop keeps");
        step(0, 0, 0, 1, 0, 0, "R7 empty keeps");
        step(1, 8'h55, 3'b001, 0, 1, 4'h4, "R8 clear with push");
        for (int i = 0; i < 7; i++) step(1, 8'h60 + 8'(i), 3'b000, 0, 0, 0, "R3 fill");
        step(1, 8'h99, 3'b010, 0, 1, 4'h4, "R8 clear with drop");

        // Receiver reset (R9)
        step(1, 8'h77, 3'b111, 1, 1, 4'h2, "R9 rx reset");
        chk8("R9 rd_data kept", rd_data, last_rd);
        step(0, 0, 0, 1, 0, 0, "R10 pop after reset");
        chk8("R10 rd_data kept", rd_data, last_rd);
        blk_mode = 0;
        step(1, 8'h81, 3'b010, 0, 0, 0, "R6 after reset");
        step(0, 0, 0, 1, 0, 0, "R2 after reset");
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule